// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block holds wall-clock time and a calendar date as packed BCD fields: tenths of a second, seconds, minutes, hours, day of month, month, two-digit year and a three-bit weekday. A pulse on `tenth_tick_i` advances the tenths digit. Each field carries into the next when it rolls over. The hour field can count in 24-hour form or in 12-hour form with a PM flag. The day-of-month limit depends on the month and, for February, on the year.

Software or a bus bridge loads any field through a write port. The port takes a field select, a data byte and a valid strobe. `wr_ready_o` is tied high, so every strobe is taken in the cycle it is offered and no back-pressure is ever applied. A strobe only changes a field while `wr_unlock_i` is 1. Otherwise it is dropped with no effect. Any accepted write restarts the tenths count at zero. This realigns the one-second phase to the write.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the outputs read: tenths 0, seconds 00, minutes 00, hour 0x12 (12-hour form, AM, twelve o'clock), day 01, month 01, year 00, weekday 0.
- R2: The tenths field counts 0 to 9 on `tenth_tick_i` pulses. The pulse that finds it at 9 returns it to 0 and advances the seconds by one.
- R3: Seconds and minutes count 00 to 59 in BCD. Each wraps to 00 and carries into the next field, with correct tens-digit carries (09 to 10).
- R4: Hour bit 7 = 1 selects 24-hour form, with bits 5:0 holding the BCD hour 00 to 23. Hour 23 wraps to 00 and starts a new day.
- R5: With hour bit 7 = 0 the hour is 12-hour form. Bits 4:0 hold the BCD hour and bit 5 is the PM flag (1 = PM). The sequence is 12, 01 … 11, 12. The flag toggles on the 11 to 12 step, and only the 11 PM to 12 AM step starts a new day.
- R6: Months 01, 03, 05, 07, 08, 10 and 12 last 31 days, and months 04, 06, 09 and 11 last 30. After the last day the day field returns to 01 and the month advances.
- R7: February lasts 29 days when the two-digit BCD year is a multiple of four (00 included), and 28 days otherwise.
- R8: The end of December 31 sets the month to 01 and advances the year in BCD. Year 99 wraps to 00.
- R9: The weekday advances once per new day through 0 to 6 and back to 0, whatever the date.
- R10: When `wr_unlock_i` is 0 a write strobe changes no field, the tenths count included.
- R11: An accepted write loads the selected field and clears the tenths to 0. A tick in the same cycle is discarded, so the next second arrives exactly ten ticks after the write. Field selects: 0 seconds, 1 minutes, 2 hour, 3 day, 4 month, 5 year, 6 weekday.
- R12: Field select 7 (the tenths) is read-only. A write to it changes nothing, even when unlocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tenth_tick_i | input | 1 | One-cycle pulse per tenth of a second |
| wr_unlock_i | input | 1 | Write-enable control bit |
| wr_valid_i | input | 1 | Write strobe |
| wr_ready_o | output | 1 | Always 1: each write is taken in its cycle |
| wr_addr_i | input | 3 | Field select |
| wr_data_i | input | 8 | Field value in BCD |
| subsec_o | output | 8 | Tenths of a second, 0 to 9 |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Bit 7 mode, bit 5 PM flag or tens bit, BCD hour |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Two-digit year, BCD |
| dow_o | output | 8 | Weekday 0 to 6 |

## Verification
A tick and an accepted write can land on the same clock edge. The write must win, and the tick must leave no trace in any field. The bench first lets the tenths count reach a nonzero value. It then presents a seconds write and a tick together for one cycle. It judges the result by a tenths value of 0 straight after that edge, by the seconds still showing the written value nine ticks later, and by the seconds advancing exactly on the tenth tick.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DATE  = 3'd3,
    FLD_MONTH = 3'd4,
    FLD_YEAR  = 3'd5,
    FLD_DOW   = 3'd6,
    FLD_SUB   = 3'd7
  } rtc_field_e;

  // Two-digit BCD increment; the caller handles the upper limit.
  function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return v + 8'd1;
  endfunction

  // Writable bits of each field.
  function automatic logic [7:0] field_mask(input rtc_field_e f);
    case (f)
      FLD_SEC, FLD_MIN: return 8'h7F;
      FLD_HOUR:         return 8'hBF;
      FLD_DATE:         return 8'h3F;
      FLD_MONTH:        return 8'h1F;
      FLD_YEAR:         return 8'hFF;
      FLD_DOW:          return 8'h07;
      default:          return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/rtc_bcd_cnt.sv
module rtc_bcd_cnt
  import rtc_cal_pkg::*;
#(
  parameter int         W      = 8,
  parameter logic [7:0] LO     = 8'h00,
  parameter logic [7:0] RST_V  = 8'h00
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inc_i,
  input  logic [W-1:0] top_i,
  output logic [W-1:0] val_o,
  output logic         wrap_o
);

  logic [W-1:0] q;
  logic         at_top;

  assign at_top = (q >= top_i);
  assign wrap_o = inc_i & at_top;
  assign val_o  = q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= W'(RST_V);
    else if (load_i)  q <= load_val_i;
    else if (inc_i)   q <= at_top ? W'(LO) : W'(bcd_inc8(8'(q)));
  end

  AST_WRAP_TO_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && (q >= top_i)) |=> (q == W'(LO))); // R3

endmodule

// File: rtl/rtc_hour_cnt.sv
module rtc_hour_cnt
  import rtc_cal_pkg::*;
#(
  parameter logic [7:0] RST_V = 8'h12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] load_val_i,
  input  logic       inc_i,
  output logic [7:0] hour_o,
  output logic       day_o
);

  logic [7:0] q;
  logic [7:0] nxt;
  logic [7:0] inc_tmp;
  logic       day_nxt;

  always_comb begin
    nxt     = q;
    day_nxt = 1'b0;
    inc_tmp = bcd_inc8({2'b00, q[5:0]});
    if (q[7]) begin
      if (q[5:0] >= 6'h23) begin
        nxt     = 8'h80;
        day_nxt = 1'b1;
      end else begin
        nxt = {q[7:6], inc_tmp[5:0]};
      end
    end else begin
      inc_tmp = bcd_inc8({3'b000, q[4:0]});
      if (q[4:0] == 5'h12) begin
        nxt = {q[7:5], 5'h01};
      end else if (q[4:0] == 5'h11) begin
        nxt     = {q[7:6], ~q[5], 5'h12};
        day_nxt = q[5];
      end else begin
        nxt = {q[7:5], inc_tmp[4:0]};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= RST_V;
    else if (load_i) q <= load_val_i;
    else if (inc_i)  q <= nxt;
  end

  assign hour_o = q;
  assign day_o  = inc_i & day_nxt;

  AST_PM_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && !q[7] && q[4:0] == 5'h11) |=> (q[5] != $past(q[5]))); // R5

  // R5 also covered: the day starts at 12 AM in 12-hour form.
  AST_MIDNIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (day_o && !load_i) |=> (q[7] ? (q[5:0] == 6'h00) : (q[5:0] == 6'h12))); // R4

endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len (
  input  logic [7:0] month_i,
  input  logic [4:0] year_lsb_i,
  output logic [7:0] last_o
);

  logic leap;

  // BCD year divisible by four: an even tens digit needs ones 0/4/8, an odd one needs 2/6.
  always_comb begin
    if (year_lsb_i[4])
      leap = (year_lsb_i[3:0] == 4'd2) || (year_lsb_i[3:0] == 4'd6);
    else
      leap = (year_lsb_i[3:0] == 4'd0) || (year_lsb_i[3:0] == 4'd4) ||
             (year_lsb_i[3:0] == 4'd8);
  end

  always_comb begin
    case (month_i)
      8'h02:                      last_o = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_o = 8'h30;
      default:                    last_o = 8'h31;
    endcase
  end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8,
  parameter int SUB_LAST = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tenth_tick_i,
  input  logic              wr_unlock_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] subsec_o,
  output logic [DATA_W-1:0] sec_o,
  output logic [DATA_W-1:0] min_o,
  output logic [DATA_W-1:0] hour_o,
  output logic [DATA_W-1:0] date_o,
  output logic [DATA_W-1:0] month_o,
  output logic [DATA_W-1:0] year_o,
  output logic [DATA_W-1:0] dow_o
);

  localparam int NFLD = 7;
  localparam logic [DATA_W-1:0] SUB_TOP = DATA_W'(SUB_LAST);

  logic              wr_take;
  logic              tick;
  logic [NFLD-1:0]   ld;
  logic [DATA_W-1:0] ld_val;
  rtc_field_e        sel;

  logic sub_wrap, sec_wrap, min_wrap, day_carry, date_wrap, month_wrap;
  logic year_wrap, dow_wrap;
  logic [7:0] month_last;

  assign wr_ready_o = 1'b1;
  assign sel        = rtc_field_e'(wr_addr_i);
  assign wr_take    = wr_valid_i & wr_unlock_i & (sel != FLD_SUB);
  assign tick       = tenth_tick_i & ~wr_take;
  assign ld_val     = wr_data_i & DATA_W'(field_mask(sel));

  for (genvar f = 0; f < NFLD; f++) begin : g_ld
    assign ld[f] = wr_take & (wr_addr_i == ADDR_W'(f));
  end

  rtc_bcd_cnt #(.W(DATA_W), .LO(8'h00), .RST_V(8'h00)) u_sub (
    .clk_i, .rst_ni, .load_i(wr_take), .load_val_i('0), .inc_i(tick),
    .top_i(SUB_TOP), .val_o(subsec_o), .wrap_o(sub_wrap));

  rtc_bcd_cnt #(.W(DATA_W), .LO(8'h00), .RST_V(8'h00)) u_sec (
    .clk_i, .rst_ni, .load_i(ld[FLD_SEC]), .load_val_i(ld_val), .inc_i(sub_wrap),
    .top_i(DATA_W'(8'h59)), .val_o(sec_o), .wrap_o(sec_wrap));

  rtc_bcd_cnt #(.W(DATA_W), .LO(8'h00), .RST_V(8'h00)) u_min (
    .clk_i, .rst_ni, .load_i(ld[FLD_MIN]), .load_val_i(ld_val), .inc_i(sec_wrap),
    .top_i(DATA_W'(8'h59)), .val_o(min_o), .wrap_o(min_wrap));

  rtc_hour_cnt #(.RST_V(8'h12)) u_hour (
    .clk_i, .rst_ni, .load_i(ld[FLD_HOUR]), .load_val_i(ld_val), .inc_i(min_wrap),
    .hour_o(hour_o), .day_o(day_carry));

  rtc_month_len u_mlen (
    .month_i(month_o), .year_lsb_i(year_o[4:0]), .last_o(month_last));

  rtc_bcd_cnt #(.W(DATA_W), .LO(8'h01), .RST_V(8'h01)) u_date (
    .clk_i, .rst_ni, .load_i(ld[FLD_DATE]), .load_val_i(ld_val), .inc_i(day_carry),
    .top_i(month_last), .val_o(date_o), .wrap_o(date_wrap));

  rtc_bcd_cnt #(.W(DATA_W), .LO(8'h01), .RST_V(8'h01)) u_month (
    .clk_i, .rst_ni, .load_i(ld[FLD_MONTH]), .load_val_i(ld_val), .inc_i(date_wrap),
    .top_i(DATA_W'(8'h12)), .val_o(month_o), .wrap_o(month_wrap));

  rtc_bcd_cnt #(.W(DATA_W), .LO(8'h00), .RST_V(8'h00)) u_year (
    .clk_i, .rst_ni, .load_i(ld[FLD_YEAR]), .load_val_i(ld_val), .inc_i(month_wrap),
    .top_i(DATA_W'(8'h99)), .val_o(year_o), .wrap_o(year_wrap));

  rtc_bcd_cnt #(.W(DATA_W), .LO(8'h00), .RST_V(8'h00)) u_dow (
    .clk_i, .rst_ni, .load_i(ld[FLD_DOW]), .load_val_i(ld_val), .inc_i(day_carry),
    .top_i(DATA_W'(8'h06)), .val_o(dow_o), .wrap_o(dow_wrap));

  AST_SUBSEC_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_unlock_i && sel != FLD_SUB) |=> (subsec_o == '0)); // R11

  AST_LOCKED_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !wr_unlock_i && !tenth_tick_i) |=>
      ($stable(subsec_o) && $stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
       $stable(date_o) && $stable(month_o) && $stable(year_o) && $stable(dow_o))); // R10

  AST_SUBSEC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    subsec_o <= SUB_TOP); // R2

  AST_MONTH_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (day_carry && !wr_take && date_o >= month_last) |=> (date_o == DATA_W'(8'h01))); // R6

  AST_YEAR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (year_wrap && !wr_take) |=> (year_o == '0)); // R8

  AST_DOW_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dow_wrap && !wr_take) |=> (dow_o == '0)); // R9

endmodule

// File: tb/rtc_calendar_tb.sv
module rtc_calendar_tb_top;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tenth_tick_i = 1'b0;
  logic       wr_unlock_i = 1'b0;
  logic       wr_valid_i = 1'b0;
  logic       wr_ready_o;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] subsec_o, sec_o, min_o, hour_o, date_o, month_o, year_o, dow_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  rtc_calendar dut_i (.*);

  task automatic chk(input string req, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_valid_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_valid_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk_i);
    tenth_tick_i = 1'b1;
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
    tenth_tick_i = 1'b0;
  endtask

  // Set 23:59:59 (24-hour) on the given date, then run one second.
  task automatic end_of_day(input logic [7:0] d, input logic [7:0] m, input logic [7:0] y);
    wr(3'd2, 8'hA3); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    wr(3'd5, y); wr(3'd4, m); wr(3'd3, d);
    ticks(10);
  endtask

  task automatic t_reset;
    chk("R1", "subsec", subsec_o, 8'h00); chk("R1", "sec", sec_o, 8'h00);
    chk("R1", "min", min_o, 8'h00);       chk("R1", "hour", hour_o, 8'h12);
    chk("R1", "date", date_o, 8'h01);     chk("R1", "month", month_o, 8'h01);
    chk("R1", "year", year_o, 8'h00);     chk("R1", "dow", dow_o, 8'h00);
    chk("R1", "ready", {7'b0, wr_ready_o}, 8'h01);
  endtask

  task automatic t_subsec;
    wr(3'd0, 8'h00);
    ticks(9);
    chk("R2", "subsec at 9", subsec_o, 8'h09); chk("R2", "sec held", sec_o, 8'h00);
    ticks(1);
    chk("R2", "subsec wrap", subsec_o, 8'h00); chk("R2", "sec step", sec_o, 8'h01);
  endtask

  task automatic t_sec_min;
    wr(3'd1, 8'h09); wr(3'd0, 8'h59);
    ticks(10);
    chk("R3", "sec wrap", sec_o, 8'h00); chk("R3", "min tens carry", min_o, 8'h10);
    wr(3'd2, 8'h85); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    ticks(10);
    chk("R3", "min wrap", min_o, 8'h00); chk("R4", "hour 24h step", hour_o, 8'h86);
  endtask

  task automatic t_24h;
    wr(3'd6, 8'h06);
    end_of_day(8'h14, 8'h03, 8'h21);
    chk("R4", "hour 23->00", hour_o, 8'h80); chk("R4", "date", date_o, 8'h15);
    chk("R9", "dow 6->0", dow_o, 8'h00);
  endtask

  task automatic t_12h;
    wr(3'd3, 8'h07); wr(3'd6, 8'h02);
    wr(3'd2, 8'h11); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    ticks(10);
    chk("R5", "11AM->12PM", hour_o, 8'h32); chk("R5", "no day", date_o, 8'h07);
    wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    ticks(10);
    chk("R5", "12PM->1PM", hour_o, 8'h21);
    wr(3'd2, 8'h31); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    ticks(10);
    chk("R5", "11PM->12AM", hour_o, 8'h12); chk("R5", "new day", date_o, 8'h08);
    chk("R9", "dow step", dow_o, 8'h03);
  endtask

  task automatic t_months;
    end_of_day(8'h30, 8'h04, 8'h21);
    chk("R6", "Apr30 date", date_o, 8'h01); chk("R6", "Apr30 month", month_o, 8'h05);
    end_of_day(8'h30, 8'h03, 8'h21);
    chk("R6", "Mar30 date", date_o, 8'h31); chk("R6", "Mar30 month", month_o, 8'h03);
    end_of_day(8'h31, 8'h07, 8'h21);
    chk("R6", "Jul31 month", month_o, 8'h08);
    end_of_day(8'h30, 8'h11, 8'h21);
    chk("R6", "Nov30 month", month_o, 8'h12); chk("R6", "Nov30 date", date_o, 8'h01);
  endtask

  task automatic t_leap;
    end_of_day(8'h28, 8'h02, 8'h24);
    chk("R7", "y24 Feb29", date_o, 8'h29);
    end_of_day(8'h29, 8'h02, 8'h24);
    chk("R7", "y24 Mar1 m", month_o, 8'h03); chk("R7", "y24 Mar1 d", date_o, 8'h01);
    end_of_day(8'h28, 8'h02, 8'h23);
    chk("R7", "y23 Mar1", month_o, 8'h03);
    end_of_day(8'h28, 8'h02, 8'h00);
    chk("R7", "y00 Feb29", date_o, 8'h29);
    end_of_day(8'h28, 8'h02, 8'h10);
    chk("R7", "y10 Mar1", month_o, 8'h03);
  endtask

  task automatic t_year;
    end_of_day(8'h31, 8'h12, 8'h99);
    chk("R8", "99->00", year_o, 8'h00); chk("R8", "month 01", month_o, 8'h01);
    chk("R8", "date 01", date_o, 8'h01);
    end_of_day(8'h31, 8'h12, 8'h19);
    chk("R8", "19->20", year_o, 8'h20);
  endtask

  task automatic t_lock;
    wr(3'd0, 8'h21);
    ticks(3);
    wr_unlock_i = 1'b0;
    wr(3'd0, 8'h44);
    wr(3'd4, 8'h09);
    chk("R10", "sec kept", sec_o, 8'h21); chk("R10", "subsec kept", subsec_o, 8'h03);
    chk("R10", "month kept", month_o, 8'h01);
    wr_unlock_i = 1'b1;
  endtask

  task automatic t_ro_sub;
    wr(3'd0, 8'h05);
    ticks(4);
    wr(3'd7, 8'h00);
    chk("R12", "subsec kept", subsec_o, 8'h04); chk("R12", "sec kept", sec_o, 8'h05);
  endtask

  task automatic t_coincide;
    wr(3'd0, 8'h40);
    ticks(6);
    @(negedge clk_i);
    wr_valid_i = 1'b1; wr_addr_i = 3'd0; wr_data_i = 8'h10; tenth_tick_i = 1'b1;
    @(negedge clk_i);
    wr_valid_i = 1'b0; tenth_tick_i = 1'b0;
    chk("R11", "subsec cleared", subsec_o, 8'h00); chk("R11", "sec loaded", sec_o, 8'h10);
    ticks(9);
    chk("R11", "sec after 9", sec_o, 8'h10);
    ticks(1);
    chk("R11", "sec after 10", sec_o, 8'h11);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    wr_unlock_i = 1'b1;
    t_subsec();
    t_sec_min();
    t_24h();
    t_12h();
    t_months();
    t_leap();
    t_year();
    t_lock();
    t_ro_sub();
    t_coincide();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule